// File: doc/BRIEF.md
# Input-Activity Standby Controller

This block decides whether a small programmable-logic core is running or in low-power standby. It samples a vector of input and I/O lines, plus a dedicated power-down input, on a free-running sample clock. From these it drives a standby flag, a wake-pending flag and an outputs-valid flag. It also drives two enables that gate the core's input capture and clock capture. Every delay is a count of sample-clock cycles.

A parameter selects one of two modes. In activity mode, the block drops into standby once no line has produced a qualified change for a programmed idle period. Any qualified change wakes it again. A change counts as qualified only after a minimum-width glitch filter accepts it. In pin mode, the lines play no part, and the power-down input alone controls standby. That input must respect minimum high and low widths. Leaving standby through the pin releases input capture first, then clock capture, and finally the outputs. A pin pulse that is too short sets a sticky error flag and does not change the power state.

In both modes, every change of state is followed by a recovery interval. During that interval the outputs are flagged invalid, so downstream logic knows to add the recovery time to its normal paths.

Top module: `activity_standby_ctrl`

## Requirements
- R1: While reset is high and after it is released, the block is active: standby=0, wake_pending=0, out_valid=1, in_capture_en=1, clk_capture_en=1, width_err=0.
- R2: In activity mode with no qualified change, standby rises no earlier than IDLE_MIN and no later than IDLE_MAX sample cycles after the last line change. The idle period IDLE_PERIOD is clamped into that window. While in standby, out_valid and both capture enables are 0.
- R3: In activity mode, every qualified change reloads the idle timer. Lines that toggle at intervals shorter than IDLE_MIN keep the block active indefinitely.
- R4: A line level held for fewer than NARROW_CNT samples is ignored: it causes no wake-up and no reload. A level held for WIDE_CNT samples or more is a qualified change.
- R5: In activity mode, a qualified change during standby clears standby and raises wake_pending. out_valid and both capture enables then stay 0 for RECOVER_CNT cycles. After that, all three are 1 and wake_pending is 0.
- R6: In activity mode, the power-down input has no effect: it never enters or leaves standby, and width_err stays 0.
- R7: In pin mode, holding the power-down input high (1 = power down) for PD_HI_MIN samples enters standby. Line activity has no effect in pin mode: there is no idle timeout and no wake-up from the lines.
- R8: In pin mode, a valid fall of the power-down input sets wake_pending. in_capture_en then rises IN_DLY cycles later, clk_capture_en CLK_DLY cycles later, and out_valid OUT_DLY cycles later. Each delay is counted from the synchronized fall, and IN_DLY < CLK_DLY < OUT_DLY.
- R9: In pin mode, a high pulse shorter than PD_HI_MIN sets width_err and the block stays active. A low pulse shorter than PD_LO_MIN during recovery sets width_err and returns the block to standby. width_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high reset |
| lines | input | N_LINES | Monitored input and I/O lines, asynchronous |
| pd_pin | input | 1 | Power-down request, active high, asynchronous (pin mode only) |
| standby | output | 1 | Core is in standby |
| wake_pending | output | 1 | Recovery interval in progress |
| out_valid | output | 1 | Core outputs may be trusted |
| in_capture_en | output | 1 | Core may capture its inputs |
| clk_capture_en | output | 1 | Core clock may be used |
| width_err | output | 1 | Sticky flag for a power-down pulse that violates a minimum width |

## Verification
The bench targets the idle-window edges. A timer that counts from the raw line instead of the qualified change, or that fails to reload on every change, falls asleep early or too late, or sleeps through steady activity. It also sends a one-sample glitch during standby; a filter with no width check would wake on it. In pin mode, the bench probes the staggered release of input capture, clock capture and outputs; a design that releases them together or in the wrong order is caught between the delays. Short high and short low pulses check that width_err latches, that the power state holds, and that a too-short low pulse during recovery sends the block back to standby instead of letting it finish waking.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_RECOVER = 2'd2
    } pwr_state_e;

    typedef enum logic {
        WAKE_BY_ACTIVITY = 1'b0,
        WAKE_BY_PIN      = 1'b1
    } wake_mode_e;

    typedef struct packed {
        logic standby;
        logic wake_pending;
        logic out_valid;
        logic in_en;
        logic clk_en;
    } pwr_flags_t;

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned min_u(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
        return min_u(max_u(v, lo), hi);
    endfunction

    function automatic pwr_flags_t decode_flags(pwr_state_e st, logic in_ok, logic clk_ok);
        pwr_flags_t f;
        f.standby      = (st == ST_STANDBY);
        f.wake_pending = (st == ST_RECOVER);
        f.out_valid    = (st == ST_ACTIVE);
        f.in_en        = f.out_valid | (f.wake_pending & in_ok);
        f.clk_en       = f.out_valid | (f.wake_pending & clk_ok);
        return f;
    endfunction

endpackage

// File: rtl/asc_sync.sv
module asc_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/asc_glitch_filter.sv
module asc_glitch_filter #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned QUAL    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lvl,
    output logic [N_LINES-1:0] qual_edge
);
    localparam int unsigned CW = $clog2(QUAL + 1);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic          acc;
        logic          hit;
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc <= 1'b0;
                cnt <= '0;
                hit <= 1'b0;
            end else begin
                hit <= 1'b0;
                if (lvl[i] == acc) begin
                    cnt <= '0;
                end else if (cnt == CW'(QUAL - 1)) begin
                    acc <= lvl[i];
                    cnt <= '0;
                    hit <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        assign qual_edge[i] = hit;

        // R4: a qualified change only follows a sample that differed from the accepted level
        assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (rst)
            hit |-> $past(lvl[i] != acc));
    end
endmodule

// File: rtl/asc_idle_timer.sv
module asc_idle_timer #(
    parameter int unsigned LIMIT = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic reload,
    output logic expired
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || reload || !run) begin
            cnt <= '0;
        end else if (cnt != W'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && !reload && (cnt == W'(LIMIT - 1));

    // R3: a reload always pushes expiry at least one full period away
    assert_reload_defers_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        reload |=> !expired);
endmodule

// File: rtl/asc_pin_monitor.sv
module asc_pin_monitor #(
    parameter int unsigned HI_MIN = 40,
    parameter int unsigned LO_MIN = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    output logic rose,
    output logic fell_ok,
    output logic held_high,
    output logic width_err
);
    localparam int unsigned SAT = asc_pkg::max_u(HI_MIN, LO_MIN);
    localparam int unsigned W   = $clog2(SAT + 1);

    logic         prev;
    logic         fell;
    logic         short_pulse;
    logic [W-1:0] run;

    assign rose        = pin_s & ~prev;
    assign fell        = ~pin_s & prev;
    assign fell_ok     = fell && (run >= W'(HI_MIN));
    assign short_pulse = (fell && (run < W'(HI_MIN))) || (rose && (run < W'(LO_MIN)));
    assign held_high   = pin_s && !rose && (run >= W'(HI_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= 1'b0;
            run       <= '0;
            width_err <= 1'b0;
        end else begin
            prev <= pin_s;
            if (pin_s != prev) begin
                run <= W'(1);
            end else if (run != W'(SAT)) begin
                run <= run + 1'b1;
            end
            if (short_pulse) begin
                width_err <= 1'b1;
            end
        end
    end

    // R9: the width error is sticky until reset
    assert_width_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        width_err |=> width_err);
endmodule

// File: rtl/activity_standby_ctrl.sv
module activity_standby_ctrl
    import asc_pkg::*;
#(
    parameter wake_mode_e  MODE        = WAKE_BY_ACTIVITY,
    parameter int unsigned N_LINES     = 8,
    parameter int unsigned NARROW_CNT  = 2,
    parameter int unsigned WIDE_CNT    = 10,
    parameter int unsigned IDLE_MIN    = 100,
    parameter int unsigned IDLE_MAX    = 250,
    parameter int unsigned IDLE_PERIOD = 150,
    parameter int unsigned RECOVER_CNT = 15,
    parameter int unsigned PD_HI_MIN   = 40,
    parameter int unsigned PD_LO_MIN   = 30,
    parameter int unsigned IN_DLY      = 20,
    parameter int unsigned CLK_DLY     = 30,
    parameter int unsigned OUT_DLY     = 35
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    input  logic               pd_pin,
    output logic               standby,
    output logic               wake_pending,
    output logic               out_valid,
    output logic               in_capture_en,
    output logic               clk_capture_en,
    output logic               width_err
);
    localparam bit          PIN     = (MODE == WAKE_BY_PIN);
    localparam int unsigned QUAL    = max_u(1, min_u(NARROW_CNT, WIDE_CNT));
    localparam int unsigned LIMIT   = clamp_u(IDLE_PERIOD, IDLE_MIN, IDLE_MAX);
    localparam int unsigned REC_LEN = PIN ? OUT_DLY : RECOVER_CNT;
    localparam int unsigned RW      = $clog2(max_u(max_u(RECOVER_CNT, OUT_DLY), CLK_DLY) + 1);

    logic [N_LINES:0]   raw_all, sync_all;
    logic [N_LINES-1:0] edge_vec;
    logic               pin_s, any_edge, idle_exp;
    logic               pin_rose, pin_fell_ok, pin_held, pin_err;
    logic               go_sleep, go_wake, in_ok, clk_ok;
    pwr_state_e         st, st_nxt;
    logic [RW-1:0]      rcnt;
    pwr_flags_t         flags;

    assign raw_all = {pd_pin, lines};

    asc_sync #(.WIDTH(N_LINES + 1)) u_sync (
        .clk(clk), .rst(rst), .d(raw_all), .q(sync_all)
    );

    assign pin_s = sync_all[N_LINES];

    asc_glitch_filter #(.N_LINES(N_LINES), .QUAL(QUAL)) u_filter (
        .clk(clk), .rst(rst), .lvl(sync_all[N_LINES-1:0]), .qual_edge(edge_vec)
    );

    assign any_edge = |edge_vec;

    asc_idle_timer #(.LIMIT(LIMIT)) u_idle (
        .clk(clk), .rst(rst),
        .run(!PIN && (st == ST_ACTIVE)),
        .reload(any_edge),
        .expired(idle_exp)
    );

    asc_pin_monitor #(.HI_MIN(PD_HI_MIN), .LO_MIN(PD_LO_MIN)) u_pin (
        .clk(clk), .rst(rst), .pin_s(pin_s),
        .rose(pin_rose), .fell_ok(pin_fell_ok), .held_high(pin_held), .width_err(pin_err)
    );

    assign go_sleep = PIN ? pin_held    : idle_exp;
    assign go_wake  = PIN ? pin_fell_ok : any_edge;
    assign in_ok    = PIN && (rcnt >= RW'(IN_DLY));
    assign clk_ok   = PIN && (rcnt >= RW'(CLK_DLY));

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_ACTIVE:  if (go_sleep) st_nxt = ST_STANDBY;
            ST_STANDBY: if (go_wake)  st_nxt = ST_RECOVER;
            ST_RECOVER: begin
                if (PIN && pin_rose) begin
                    st_nxt = ST_STANDBY;
                end else if (rcnt == RW'(REC_LEN - 1)) begin
                    st_nxt = ST_ACTIVE;
                end
            end
            default:    st_nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_ACTIVE;
            rcnt <= '0;
        end else begin
            st   <= st_nxt;
            rcnt <= ((st == ST_RECOVER) && (st_nxt == ST_RECOVER)) ? rcnt + 1'b1 : '0;
        end
    end

    assign flags          = decode_flags(st, in_ok, clk_ok);
    assign standby        = flags.standby;
    assign wake_pending   = flags.wake_pending;
    assign out_valid      = flags.out_valid;
    assign in_capture_en  = flags.in_en;
    assign clk_capture_en = flags.clk_en;
    assign width_err      = PIN && pin_err;

    // R5: standby is only ever left through the recovery interval
    assert_sleep_exits_via_recovery_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(standby) |-> wake_pending);

    // R5: outputs become valid only at the end of a recovery interval
    assert_valid_after_recovery_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(wake_pending));

    // R8: clock capture is never released ahead of input capture
    assert_clock_after_inputs_R8: assert property (@(posedge clk) disable iff (rst)
        clk_capture_en |-> in_capture_en);

    // R7: in pin mode, standby is entered only while the pin is high
    assert_pin_standby_needs_high_R7: assert property (@(posedge clk) disable iff (rst)
        (PIN && $rose(standby)) |-> pin_s);

    // R5: in activity mode, a wake-up follows a qualified line change
    assert_wake_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (!PIN && $rose(wake_pending)) |-> $past(any_edge));
endmodule

// File: tb/test_activity_standby_ctrl.sv
module test_activity_standby_ctrl;
    import asc_pkg::*;

    localparam int unsigned NL        = 8;
    localparam int unsigned IDLE_MIN  = 100;
    localparam int unsigned IDLE_MAX  = 250;
    localparam int unsigned WIDE      = 10;
    localparam int unsigned HI_MIN    = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] lines_a = '0, lines_p = '0;
    logic          pin_a = 1'b0, pin_p = 1'b0;
    logic sb_a, wk_a, ov_a, ie_a, ce_a, er_a;
    logic sb_p, wk_p, ov_p, ie_p, ce_p, er_p;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    activity_standby_ctrl #(.MODE(WAKE_BY_ACTIVITY)) i_activity_standby_ctrl (
        .clk(clk), .rst(rst), .lines(lines_a), .pd_pin(pin_a),
        .standby(sb_a), .wake_pending(wk_a), .out_valid(ov_a),
        .in_capture_en(ie_a), .clk_capture_en(ce_a), .width_err(er_a)
    );

    activity_standby_ctrl #(.MODE(WAKE_BY_PIN)) i_activity_standby_ctrl_pin (
        .clk(clk), .rst(rst), .lines(lines_p), .pd_pin(pin_p),
        .standby(sb_p), .wake_pending(wk_p), .out_valid(ov_p),
        .in_capture_en(ie_p), .clk_capture_en(ce_p), .width_err(er_p)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        lines_a = '0; lines_p = '0; pin_a = 1'b0; pin_p = 1'b0;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        chk("R1", "act standby", sb_a, 1'b0);
        chk("R1", "act wake_pending", wk_a, 1'b0);
        chk("R1", "act out_valid", ov_a, 1'b1);
        chk("R1", "act in_en", ie_a, 1'b1);
        chk("R1", "act clk_en", ce_a, 1'b1);
        chk("R1", "pin standby", sb_p, 1'b0);
        chk("R1", "pin out_valid", ov_p, 1'b1);
        chk("R1", "pin width_err", er_p, 1'b0);
    endtask

    task automatic t_idle();
        lines_a[0] = 1'b1;
        step(IDLE_MIN);
        chk("R2", "standby before min window", sb_a, 1'b0);
        step(IDLE_MAX - IDLE_MIN);
        chk("R2", "standby after max window", sb_a, 1'b1);
        chk("R2", "out_valid in standby", ov_a, 1'b0);
        chk("R2", "in_en in standby", ie_a, 1'b0);
    endtask

    task automatic t_act_pin_ignored();
        pin_a = 1'b1; step(60);
        pin_a = 1'b0; step(5);
        pin_a = 1'b1; step(5);
        pin_a = 1'b0; step(20);
        chk("R6", "standby held despite pin", sb_a, 1'b1);
        chk("R6", "no wake from pin", wk_a, 1'b0);
        chk("R6", "width_err stays low", er_a, 1'b0);
    endtask

    task automatic t_glitch_wake();
        lines_a[3] = 1'b1; step(1);
        lines_a[3] = 1'b0; step(20);
        chk("R4", "glitch leaves standby set", sb_a, 1'b1);
        chk("R4", "glitch raises no wake", wk_a, 1'b0);
        lines_a[5] = 1'b1;
        step(WIDE);
        chk("R5", "wake_pending after wide change", wk_a, 1'b1);
        chk("R5", "standby cleared on wake", sb_a, 1'b0);
        chk("R5", "in_en low in recovery", ie_a, 1'b0);
        step(6);
        chk("R5", "out_valid low in recovery", ov_a, 1'b0);
        step(8);
        chk("R5", "out_valid after recovery", ov_a, 1'b1);
        chk("R5", "wake_pending cleared", wk_a, 1'b0);
        chk("R5", "clk_en after recovery", ce_a, 1'b1);
    endtask

    task automatic t_activity_keeps();
        for (int k = 0; k < 5; k++) begin
            lines_a[1] = ~lines_a[1];
            step(80);
            chk("R3", "active under steady toggling", sb_a, 1'b0);
        end
        step(IDLE_MAX);
        chk("R3", "standby once toggling stops", sb_a, 1'b1);
    endtask

    task automatic t_pin_lines_ignored();
        for (int k = 0; k < 4; k++) begin
            lines_p = ~lines_p;
            step(20);
        end
        step(300);
        chk("R7", "no idle timeout in pin mode", sb_p, 1'b0);
        chk("R7", "no wake in pin mode", wk_p, 1'b0);
    endtask

    task automatic t_pin_enter();
        pin_p = 1'b1;
        step(HI_MIN / 2);
        chk("R7", "not yet in standby", sb_p, 1'b0);
        step(HI_MIN / 2 + 8);
        chk("R7", "standby after held high", sb_p, 1'b1);
        chk("R7", "clk_en low in standby", ce_p, 1'b0);
        lines_p = ~lines_p;
        step(20);
        chk("R7", "lines do not wake", sb_p, 1'b1);
    endtask

    task automatic t_pin_wake();
        pin_p = 1'b0;
        step(5);
        chk("R8", "wake_pending after fall", wk_p, 1'b1);
        chk("R8", "in_en low early", ie_p, 1'b0);
        step(16);
        chk("R8", "in_en low before IN_DLY", ie_p, 1'b0);
        step(5);
        chk("R8", "in_en after IN_DLY", ie_p, 1'b1);
        chk("R8", "clk_en still low", ce_p, 1'b0);
        step(5);
        chk("R8", "clk_en low before CLK_DLY", ce_p, 1'b0);
        step(4);
        chk("R8", "clk_en after CLK_DLY", ce_p, 1'b1);
        chk("R8", "out_valid still low", ov_p, 1'b0);
        step(1);
        chk("R8", "out_valid low before OUT_DLY", ov_p, 1'b0);
        step(6);
        chk("R8", "out_valid after OUT_DLY", ov_p, 1'b1);
        chk("R8", "wake_pending cleared", wk_p, 1'b0);
        chk("R8", "no width error on valid pulses", er_p, 1'b0);
    endtask

    task automatic t_pin_short_high();
        step(50);
        pin_p = 1'b1; step(10);
        pin_p = 1'b0; step(60);
        chk("R9", "short high flags error", er_p, 1'b1);
        chk("R9", "short high keeps active", sb_p, 1'b0);
        chk("R9", "short high keeps out_valid", ov_p, 1'b1);
    endtask

    task automatic t_pin_short_low();
        step(50);
        pin_p = 1'b1; step(60);
        chk("R9", "standby before short low", sb_p, 1'b1);
        pin_p = 1'b0; step(10);
        chk("R9", "recovery started", wk_p, 1'b1);
        pin_p = 1'b1; step(10);
        chk("R9", "short low returns to standby", sb_p, 1'b1);
        chk("R9", "short low flags error", er_p, 1'b1);
        step(50);
        pin_p = 1'b0; step(50);
        chk("R9", "later valid wake completes", ov_p, 1'b1);
        chk("R9", "error stays sticky", er_p, 1'b1);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_idle();
        t_act_pin_ignored();
        t_glitch_wake();
        t_activity_keeps();
        do_reset();
        t_pin_lines_ignored();
        t_pin_enter();
        t_pin_wake();
        do_reset();
        t_pin_short_high();
        do_reset();
        t_pin_short_low();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule